// File: doc/BRIEF.md
# Linked-List DMA Channel Engine

This block is one DMA channel that carries out a transfer made of several blocks. Before each block it reads a four-word descriptor from memory. The descriptor supplies the destination address, the link to the next descriptor and a control word. The source address does not come from the descriptor. At the start of every block it is reloaded from a value that software programmed once, so each block reads the same source region again. The destination address moves from one descriptor to the next.

Software uses the block in four steps:

1. Write the source start address, the first descriptor pointer and the handshake configuration.
2. Clear any old interrupts.
3. Set the global enable and the channel enable together.
4. Wait for the interrupt, or poll the channel enable bit until hardware clears it.

The engine moves data through a simple memory master port. Each data item is one 32-bit word: it is read from the source and then written to the destination. Items move in transactions of 1, 4 or 8. When a side of the transfer is a peripheral, a transaction starts only when that side has requested it, either by a hardware request line or by a software request bit.

Top module: `dma_ll_channel`

## Requirements
- R1: Writing the channel register (index 4) with bit 1 (channel enable) and bit 0 (global enable) both set starts the channel. The engine then reads the descriptor at the next-pointer register (index 2) as four word reads, at P, P+4, P+8 and P+12, in that order. If the write sets bit 1 with bit 0 clear, the channel does not start, no memory access is made, and channel enable reads back 0.
- R2: Every block reads its source items starting at the programmed source register (index 0), stepping up by 4. Word 0 of the descriptor is read but has no effect.
- R3: The destination address of a block is descriptor word 1. Control bits [13:12] set the destination step: 0 increments by 4, 1 decrements by 4, and 2 or 3 keeps the address fixed. The block length is control bits [11:0], counted in items.
- R4: Another descriptor is fetched from descriptor word 2 only when that word is non-zero and control bit 16 (last) is clear. Otherwise the chain ends after the current block.
- R5: When a block completes, the engine writes the block's control word back to descriptor address +12 with bit 17 (done) set.
- R6: Every completed block sets raw interrupt bit 1 (block). The final block also sets raw bit 0 (transfer), and hardware clears channel enable (bit 1 of index 4).
- R7: Control bits [15:14] set the burst size: 0 gives 1 item, 1 gives 4 items, and 2 or 3 gives 8 items. While at least one full burst remains, the engine runs burst transactions. The items left over move as single transactions.
- R8: Configuration register (index 3) bits: bit 2 marks the source as a peripheral and bit 3 marks the destination as a peripheral. Bit 0 (source) and bit 1 (destination) select the request type: 0 selects the hardware request line and 1 selects the software request register (index 5, bits 0 and 1). A transaction waits until every peripheral side has a request. Each hardware side gets a one-cycle ack per transaction, and raw bits 2 (source) and 3 (destination) are set for each peripheral side.
- R9: Writing 1s to the clear register (index 9) clears the matching raw bits (index 6). The status register (index 8) reads raw AND mask (index 7). The irq output is the OR of the status bits.
- R10: An error response on any memory access sets raw bit 4 and clears channel enable at once. No further memory access is made after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Masked interrupt output |
| mem_req | output | 1 | Memory access request, held until ack |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Error response, valid with ack |
| mem_rdata | input | 32 | Read data, valid with ack |
| hs_src_req | input | 1 | Hardware request from the source peripheral |
| hs_src_ack | output | 1 | Transaction ack to the source peripheral |
| hs_dst_req | input | 1 | Hardware request from the destination peripheral |
| hs_dst_ack | output | 1 | Transaction ack to the destination peripheral |

## Verification
The hardest state to reach from the ports is a channel that has finished its descriptor fetch and is parked in front of a transaction. In that state one side has already requested and the other has not. The bench creates it with a hardware-request source whose request line is held low and a destination set to software requests. It first raises the hardware line, then writes the software request bit. At each step it confirms that the memory port has made no access beyond the four descriptor reads. Chains that mix incrementing, decrementing and fixed destinations, with a last flag set on a descriptor whose link is non-zero, show that the source region is read again from its start in every block.

// File: rtl/dma_ll_pkg.sv
package dma_ll_pkg;

    localparam int DATA_W  = 32;
    localparam int LEN_W   = 12;
    localparam int STEP_B  = DATA_W / 8;
    localparam int RIDX_W  = 4;
    localparam int NIRQ    = 5;

    localparam logic [RIDX_W-1:0] REG_SRC   = 4'd0;
    localparam logic [RIDX_W-1:0] REG_DST   = 4'd1;
    localparam logic [RIDX_W-1:0] REG_NEXT  = 4'd2;
    localparam logic [RIDX_W-1:0] REG_CFG   = 4'd3;
    localparam logic [RIDX_W-1:0] REG_CHAN  = 4'd4;
    localparam logic [RIDX_W-1:0] REG_SWREQ = 4'd5;
    localparam logic [RIDX_W-1:0] REG_RAW   = 4'd6;
    localparam logic [RIDX_W-1:0] REG_MASK  = 4'd7;
    localparam logic [RIDX_W-1:0] REG_STAT  = 4'd8;
    localparam logic [RIDX_W-1:0] REG_CLR   = 4'd9;
    localparam logic [RIDX_W-1:0] REG_CTL   = 4'd10;

    typedef enum logic [3:0] {
        ST_IDLE, ST_FETCH, ST_SETUP, ST_WAIT, ST_RD, ST_WR, ST_TEND, ST_WB, ST_BEND
    } eng_st_e;

    typedef struct packed {
        logic [13:0]      rsvd;
        logic             done;
        logic             last;
        logic [1:0]       burst;
        logic [1:0]       dmode;
        logic [LEN_W-1:0] len;
    } ctl_word_t;

    typedef struct packed {
        logic dst_periph;
        logic src_periph;
        logic dst_sw;
        logic src_sw;
    } hs_cfg_t;

    typedef struct packed {
        logic err;
        logic dsttran;
        logic srctran;
        logic blk;
        logic tfr;
    } irq_vec_t;

    function automatic logic [LEN_W-1:0] burst_items(input logic [1:0] code);
        case (code)
            2'd0:    return LEN_W'(1);
            2'd1:    return LEN_W'(4);
            default: return LEN_W'(8);
        endcase
    endfunction

endpackage

// File: rtl/dma_ll_regs.sv
module dma_ll_regs
    import dma_ll_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [RIDX_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    input  logic [AW-1:0]     cur_dst,
    input  ctl_word_t         cur_ctl,
    output logic [AW-1:0]     src_init,
    output logic [AW-1:0]     llp,
    output hs_cfg_t           hs_cfg,
    output logic              start,
    output logic              sw_src_pend,
    output logic              sw_dst_pend,
    input  logic              sw_src_take,
    input  logic              sw_dst_take,
    input  irq_vec_t          ev,
    input  logic              ch_clr
);

    logic     glb_q, ch_q;
    irq_vec_t raw_q, mask_q, clr_v;
    logic     sw_src_set, sw_dst_set;

    assign start      = reg_we && reg_addr == REG_CHAN && reg_wdata[1] && reg_wdata[0] && !ch_q;
    assign clr_v      = (reg_we && reg_addr == REG_CLR) ? irq_vec_t'(reg_wdata[NIRQ-1:0]) : '0;
    assign sw_src_set = reg_we && reg_addr == REG_SWREQ && reg_wdata[0];
    assign sw_dst_set = reg_we && reg_addr == REG_SWREQ && reg_wdata[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            src_init    <= '0;
            llp         <= '0;
            hs_cfg      <= '0;
            glb_q       <= 1'b0;
            ch_q        <= 1'b0;
            raw_q       <= '0;
            mask_q      <= '0;
            sw_src_pend <= 1'b0;
            sw_dst_pend <= 1'b0;
        end else begin
            if (reg_we) begin
                case (reg_addr)
                    REG_SRC:  src_init <= reg_wdata[AW-1:0];
                    REG_NEXT: llp      <= reg_wdata[AW-1:0];
                    REG_CFG:  hs_cfg   <= hs_cfg_t'(reg_wdata[3:0]);
                    REG_CHAN: glb_q    <= reg_wdata[0];
                    REG_MASK: mask_q   <= irq_vec_t'(reg_wdata[NIRQ-1:0]);
                    default: ;
                endcase
            end
            if (ch_clr)     ch_q <= 1'b0;
            else if (start) ch_q <= 1'b1;
            raw_q       <= (raw_q & ~clr_v) | ev;
            sw_src_pend <= (sw_src_pend & ~sw_src_take) | sw_src_set;
            sw_dst_pend <= (sw_dst_pend & ~sw_dst_take) | sw_dst_set;
        end
    end

    always_comb begin
        case (reg_addr)
            REG_SRC:   reg_rdata = DATA_W'(src_init);
            REG_DST:   reg_rdata = DATA_W'(cur_dst);
            REG_NEXT:  reg_rdata = DATA_W'(llp);
            REG_CFG:   reg_rdata = DATA_W'(hs_cfg);
            REG_CHAN:  reg_rdata = DATA_W'({ch_q, glb_q});
            REG_SWREQ: reg_rdata = DATA_W'({sw_dst_pend, sw_src_pend});
            REG_RAW:   reg_rdata = DATA_W'(raw_q);
            REG_MASK:  reg_rdata = DATA_W'(mask_q);
            REG_STAT:  reg_rdata = DATA_W'(raw_q & mask_q);
            REG_CTL:   reg_rdata = DATA_W'(cur_ctl);
            default:   reg_rdata = '0;
        endcase
    end

    assign irq = |(raw_q & mask_q);

    AST_TFR_DROPS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(raw_q.tfr) |-> !ch_q);  // R6
    AST_START_NEEDS_GLOBAL: assert property (@(posedge clk) disable iff (rst)
        $rose(ch_q) |-> glb_q);  // R1
    AST_ERR_DROPS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(raw_q.err) |-> !ch_q);  // R10

endmodule

// File: rtl/dma_ll_engine.sv
module dma_ll_engine
    import dma_ll_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [AW-1:0]     src_init,
    input  logic [AW-1:0]     llp,
    input  hs_cfg_t           hs_cfg,
    input  logic              sw_src_pend,
    input  logic              sw_dst_pend,
    input  logic              hs_src_req,
    input  logic              hs_dst_req,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              hs_src_ack,
    output logic              hs_dst_ack,
    output logic              sw_src_take,
    output logic              sw_dst_take,
    output irq_vec_t          ev,
    output logic              ch_clr,
    output logic [AW-1:0]     cur_dst,
    output ctl_word_t         cur_ctl
);

    localparam logic [AW-1:0] ASTEP = AW'(STEP_B);

    eng_st_e          st;
    logic [1:0]       fidx;
    logic [AW-1:0]    desc_ptr, nxt_ptr, src_cur, dst_cur;
    ctl_word_t        ctl, wb_word;
    logic [LEN_W-1:0] remain, beats, bsz, tran_len;
    logic [DATA_W-1:0] data_q;
    logic             src_ok, dst_ok, acc_bad, is_last, in_tend;

    assign src_ok   = !hs_cfg.src_periph || (hs_cfg.src_sw ? sw_src_pend : hs_src_req);
    assign dst_ok   = !hs_cfg.dst_periph || (hs_cfg.dst_sw ? sw_dst_pend : hs_dst_req);
    assign bsz      = burst_items(ctl.burst);
    assign tran_len = (remain >= bsz) ? bsz : LEN_W'(1);
    assign is_last  = ctl.last || (nxt_ptr == '0);
    assign in_tend  = (st == ST_TEND);

    assign mem_req = (st == ST_FETCH) || (st == ST_RD) || (st == ST_WR) || (st == ST_WB);
    assign mem_we  = (st == ST_WR) || (st == ST_WB);
    assign acc_bad = mem_req && mem_ack && mem_err;

    always_comb begin
        wb_word      = ctl;
        wb_word.done = 1'b1;
        case (st)
            ST_FETCH: mem_addr = desc_ptr + AW'(fidx) * ASTEP;
            ST_RD:    mem_addr = src_cur;
            ST_WR:    mem_addr = dst_cur;
            ST_WB:    mem_addr = desc_ptr + AW'(3) * ASTEP;
            default:  mem_addr = '0;
        endcase
        case (st)
            ST_WR:   mem_wdata = data_q;
            ST_WB:   mem_wdata = DATA_W'(wb_word);
            default: mem_wdata = '0;
        endcase
    end

    assign hs_src_ack  = in_tend && hs_cfg.src_periph && !hs_cfg.src_sw;
    assign hs_dst_ack  = in_tend && hs_cfg.dst_periph && !hs_cfg.dst_sw;
    assign sw_src_take = in_tend && hs_cfg.src_periph && hs_cfg.src_sw;
    assign sw_dst_take = in_tend && hs_cfg.dst_periph && hs_cfg.dst_sw;

    always_comb begin
        ev         = '0;
        ev.tfr     = (st == ST_BEND) && is_last;
        ev.blk     = (st == ST_BEND);
        ev.srctran = in_tend && hs_cfg.src_periph;
        ev.dsttran = in_tend && hs_cfg.dst_periph;
        ev.err     = acc_bad;
    end

    assign ch_clr  = ev.tfr || acc_bad;
    assign cur_dst = dst_cur;
    assign cur_ctl = ctl;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            fidx     <= '0;
            desc_ptr <= '0;
            nxt_ptr  <= '0;
            src_cur  <= '0;
            dst_cur  <= '0;
            ctl      <= '0;
            remain   <= '0;
            beats    <= '0;
            data_q   <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    desc_ptr <= llp;
                    fidx     <= '0;
                    st       <= ST_FETCH;
                end
                ST_FETCH: if (acc_bad) begin
                    st <= ST_IDLE;
                end else if (mem_ack) begin
                    case (fidx)
                        2'd1:    dst_cur <= mem_rdata[AW-1:0];
                        2'd2:    nxt_ptr <= mem_rdata[AW-1:0];
                        2'd3:    ctl     <= ctl_word_t'(mem_rdata);
                        default: ;
                    endcase
                    fidx <= fidx + 2'd1;
                    if (fidx == 2'd3) st <= ST_SETUP;
                end
                ST_SETUP: begin
                    src_cur <= src_init;
                    remain  <= ctl.len;
                    st      <= (ctl.len == '0) ? ST_WB : ST_WAIT;
                end
                ST_WAIT: if (src_ok && dst_ok) begin
                    beats <= tran_len;
                    st    <= ST_RD;
                end
                ST_RD: if (acc_bad) begin
                    st <= ST_IDLE;
                end else if (mem_ack) begin
                    data_q <= mem_rdata;
                    st     <= ST_WR;
                end
                ST_WR: if (acc_bad) begin
                    st <= ST_IDLE;
                end else if (mem_ack) begin
                    src_cur <= src_cur + ASTEP;
                    case (ctl.dmode)
                        2'd0:    dst_cur <= dst_cur + ASTEP;
                        2'd1:    dst_cur <= dst_cur - ASTEP;
                        default: ;
                    endcase
                    remain <= remain - LEN_W'(1);
                    beats  <= beats - LEN_W'(1);
                    st     <= (beats == LEN_W'(1)) ? ST_TEND : ST_RD;
                end
                ST_TEND: st <= (remain == '0) ? ST_WB : ST_WAIT;
                ST_WB: if (acc_bad) begin
                    st <= ST_IDLE;
                end else if (mem_ack) begin
                    st <= ST_BEND;
                end
                ST_BEND: if (is_last) begin
                    st <= ST_IDLE;
                end else begin
                    desc_ptr <= nxt_ptr;
                    fidx     <= '0;
                    st       <= ST_FETCH;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));  // R1
    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FETCH && mem_ack && !mem_err && fidx != 2'd3) |=> (mem_addr == $past(mem_addr) + ASTEP));  // R1
    AST_ERR_HALT: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && mem_err) |=> !mem_req);  // R10
    AST_NO_WAIT_EXIT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT && !src_ok) |=> !mem_req);  // R8

endmodule

// File: rtl/dma_ll_channel.sv
module dma_ll_channel
    import dma_ll_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [RIDX_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              hs_src_req,
    output logic              hs_src_ack,
    input  logic              hs_dst_req,
    output logic              hs_dst_ack
);

    logic [AW-1:0] src_init, llp, cur_dst;
    ctl_word_t     cur_ctl;
    hs_cfg_t       hs_cfg;
    irq_vec_t      ev;
    logic          start, ch_clr;
    logic          sw_src_pend, sw_dst_pend, sw_src_take, sw_dst_take;

    dma_ll_regs #(.AW(AW)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .irq         (irq),
        .cur_dst     (cur_dst),
        .cur_ctl     (cur_ctl),
        .src_init    (src_init),
        .llp         (llp),
        .hs_cfg      (hs_cfg),
        .start       (start),
        .sw_src_pend (sw_src_pend),
        .sw_dst_pend (sw_dst_pend),
        .sw_src_take (sw_src_take),
        .sw_dst_take (sw_dst_take),
        .ev          (ev),
        .ch_clr      (ch_clr)
    );

    dma_ll_engine #(.AW(AW)) u_engine (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .src_init    (src_init),
        .llp         (llp),
        .hs_cfg      (hs_cfg),
        .sw_src_pend (sw_src_pend),
        .sw_dst_pend (sw_dst_pend),
        .hs_src_req  (hs_src_req),
        .hs_dst_req  (hs_dst_req),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_ack     (mem_ack),
        .mem_err     (mem_err),
        .mem_rdata   (mem_rdata),
        .hs_src_ack  (hs_src_ack),
        .hs_dst_ack  (hs_dst_ack),
        .sw_src_take (sw_src_take),
        .sw_dst_take (sw_dst_take),
        .ev          (ev),
        .ch_clr      (ch_clr),
        .cur_dst     (cur_dst),
        .cur_ctl     (cur_ctl)
    );

endmodule

// File: tb/dma_ll_channel_test.sv
`timescale 1ns/1ps
module dma_ll_channel_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        hs_src_req = 1'b0;
    logic        hs_dst_req = 1'b0;
    logic        hs_src_ack, hs_dst_ack;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [31:0] mem [0:255];
    logic [31:0] acc_log [0:1023];
    int          acc_n = 0;
    bit          err_on = 0;
    logic [31:0] err_addr = '0;
    int          src_ack_n = 0;
    int          dst_ack_n = 0;

    always #2 clk = ~clk;

    dma_ll_channel uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_rdata(mem_rdata), .hs_src_req(hs_src_req), .hs_src_ack(hs_src_ack),
        .hs_dst_req(hs_dst_req), .hs_dst_ack(hs_dst_ack)
    );

    // memory responder: ack one cycle after request, one access at a time
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                mem_err = 1'b0;
            end else if (mem_req) begin
                if (acc_n < 1024) acc_log[acc_n] = mem_addr;
                acc_n++;
                if (err_on && mem_addr == err_addr) mem_err = 1'b1;
                else if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
                else mem_rdata = mem[mem_addr[9:2]];
                mem_ack = 1'b1;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (hs_src_ack) src_ack_n++;
            if (hs_dst_ack) dst_ack_n++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] mkctl(input int len, input int dmode, input int burst, input bit last);
        return {14'b0, 1'b0, last, 2'(burst), 2'(dmode), 12'(len)};
    endfunction

    task automatic put_desc(input logic [31:0] at, input logic [31:0] junk, input logic [31:0] dst,
                            input logic [31:0] nxt, input logic [31:0] ctl);
        mem[at[9:2]]     = junk;
        mem[at[9:2] + 1] = dst;
        mem[at[9:2] + 2] = nxt;
        mem[at[9:2] + 3] = ctl;
    endtask

    task automatic launch(input logic [31:0] ptr, input logic [31:0] cfg);
        reg_write(4'd0, 32'h100);
        reg_write(4'd2, ptr);
        reg_write(4'd3, cfg);
        reg_write(4'd9, 32'h1F);
        acc_n = 0; src_ack_n = 0; dst_ack_n = 0;
        reg_write(4'd4, 32'h3);
    endtask

    task automatic wait_idle(input string tag);
        logic [31:0] v;
        bit done = 0;
        for (int i = 0; i < 3000 && !done; i++) begin
            reg_read(4'd4, v);
            if (v[1] == 1'b0) done = 1;
        end
        chk({tag, " channel self-disable"}, 32'(done), 32'd1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        reg_read(4'd4, v); chk("R1 reset channel reg", v, 32'h0);
        reg_read(4'd6, v); chk("R9 reset raw", v, 32'h0);
        chk("R9 reset irq", 32'(irq), 32'h0);
        chk("R1 reset mem_req", 32'(mem_req), 32'h0);
    endtask

    task automatic t_no_global();
        logic [31:0] v;
        put_desc(32'h40, 32'h3F0, 32'h200, 32'h0, mkctl(1, 0, 0, 1));
        reg_write(4'd2, 32'h40);
        acc_n = 0;
        reg_write(4'd4, 32'h2);
        repeat (20) @(negedge clk);
        chk("R1 no access without global enable", 32'(acc_n), 32'd0);
        reg_read(4'd4, v); chk("R1 channel enable stays clear", v, 32'h0);
    endtask

    task automatic t_chain();
        logic [31:0] v;
        put_desc(32'h40, 32'h3F0, 32'h200, 32'h60, mkctl(3, 0, 0, 0));
        put_desc(32'h60, 32'h120, 32'h300, 32'h0,  mkctl(3, 1, 0, 0));
        launch(32'h40, 32'h0);
        wait_idle("R6");
        chk("R1 fetch word0", acc_log[0], 32'h40);
        chk("R1 fetch word1", acc_log[1], 32'h44);
        chk("R1 fetch word2", acc_log[2], 32'h48);
        chk("R1 fetch word3", acc_log[3], 32'h4C);
        chk("R2 first data read at source start", acc_log[4], 32'h100);
        for (int i = 0; i < 3; i++) begin
            chk("R3 incrementing dst", mem[(32'h200 >> 2) + i], 32'hA000_0000 + 32'(i));
            chk("R2 source reloaded, R3 decrementing dst", mem[(32'h300 >> 2) - i], 32'hA000_0000 + 32'(i));
        end
        chk("R5 done written back block 1", mem[32'h4C >> 2], mkctl(3, 0, 0, 0) | 32'h2_0000);
        chk("R5 done written back block 2", mem[32'h6C >> 2], mkctl(3, 1, 0, 0) | 32'h2_0000);
        chk("R4 chain access count", 32'(acc_n), 32'd22);
        reg_read(4'd6, v); chk("R6 raw transfer and block", v, 32'h3);
        reg_read(4'd4, v); chk("R6 channel enable cleared", v, 32'h1);
    endtask

    task automatic t_fixed_last();
        mem[32'h300 >> 2] = 32'hDEAD_0000;
        put_desc(32'h80, 32'h0, 32'h380, 32'h60, mkctl(2, 2, 0, 1));
        launch(32'h80, 32'h0);
        wait_idle("R4");
        chk("R3 fixed dst holds last item", mem[32'h380 >> 2], 32'hA000_0001);
        chk("R3 fixed dst next word untouched", mem[32'h384 >> 2], 32'h0);
        chk("R4 last flag stops chain", mem[32'h300 >> 2], 32'hDEAD_0000);
        chk("R4 single block access count", 32'(acc_n), 32'd9);
    endtask

    task automatic t_burst(input int bcode, input int exp_tr);
        logic [31:0] v;
        for (int i = 0; i < 10; i++) mem[(32'h200 >> 2) + i] = 32'h0;
        put_desc(32'hA0, 32'h0, 32'h200, 32'h0, mkctl(10, 0, bcode, 1));
        hs_src_req = 1'b1; hs_dst_req = 1'b1;
        launch(32'hA0, 32'hC);
        wait_idle("R7");
        hs_src_req = 1'b0; hs_dst_req = 1'b0;
        chk("R7 source transactions", 32'(src_ack_n), 32'(exp_tr));
        chk("R7 destination transactions", 32'(dst_ack_n), 32'(exp_tr));
        chk("R7 last item moved", mem[(32'h200 >> 2) + 9], 32'hA000_0009);
        reg_read(4'd6, v); chk("R8 tran raw bits", v, 32'hF);
    endtask

    task automatic t_handshake();
        logic [31:0] v;
        mem[32'h200 >> 2] = 32'h0;
        put_desc(32'hA0, 32'h0, 32'h200, 32'h0, mkctl(1, 0, 0, 1));
        launch(32'hA0, 32'hE);
        repeat (30) @(negedge clk);
        chk("R8 wait for both requests", 32'(acc_n), 32'd4);
        hs_src_req = 1'b1;
        repeat (20) @(negedge clk);
        chk("R8 wait for software request", 32'(acc_n), 32'd4);
        reg_write(4'd5, 32'h2);
        wait_idle("R8");
        hs_src_req = 1'b0;
        chk("R8 item moved after requests", mem[32'h200 >> 2], 32'hA000_0000);
        chk("R8 hardware ack on source", 32'(src_ack_n), 32'd1);
        chk("R8 no hardware ack on software side", 32'(dst_ack_n), 32'd0);
        reg_read(4'd5, v); chk("R8 software request consumed", v, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        reg_write(4'd7, 32'h2);
        reg_read(4'd8, v); chk("R9 masked status", v, 32'h2);
        chk("R9 irq asserted", 32'(irq), 32'h1);
        reg_write(4'd9, 32'h1F);
        reg_read(4'd6, v); chk("R9 raw cleared", v, 32'h0);
        chk("R9 irq released", 32'(irq), 32'h0);
        reg_write(4'd7, 32'h0);
    endtask

    task automatic t_error();
        logic [31:0] v;
        int n;
        put_desc(32'hA0, 32'h0, 32'h200, 32'h0, mkctl(1, 0, 0, 1));
        err_addr = 32'hA8; err_on = 1;
        launch(32'hA0, 32'h0);
        wait_idle("R10");
        err_on = 0;
        reg_read(4'd6, v); chk("R10 error raw bit", v, 32'h10);
        n = acc_n;
        chk("R10 stop at faulting access", 32'(n), 32'd3);
        repeat (20) @(negedge clk);
        chk("R10 no access after error", 32'(acc_n), 32'(n));
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        for (int i = 0; i < 16; i++) mem[(32'h100 >> 2) + i] = 32'hA000_0000 + 32'(i);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_no_global();
        t_chain();
        t_fixed_last();
        t_burst(1, 4);
        t_burst(2, 3);
        t_handshake();
        t_irq();
        t_error();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule